// File: doc/BRIEF.md
# External Master Line-Buffer Bridge

This bridge connects a 16-bit external bus master to a 128-bit internal memory path. The master first raises a hold request. Once the bridge grants it, the master presents one access at a time: a strobe, a read/write flag, a halfword address and write data. Each access ends with a one-cycle ready pulse.

A single 128-bit line register sits between the two widths. For a read, the whole line is fetched in one internal transfer, and further reads inside that line are served from the register. For writes, halfwords are merged into the register under a per-halfword valid mask. The merged line is committed with byte enables when the master moves to another line, when it reads, or when it drops hold.

In cache mode, every internal transfer goes to either the cache port or the memory port, selected by an external hit signal for the line being looked up. A read miss never fills the cache, and a write miss never allocates in it.

Top module: `xm_line_bridge`

## Requirements
- R1: `hold_ack` rises one cycle after `hold_req` is seen high. While `hold_ack` is low, `sel` is ignored: no `rdy` and no internal request.
- R2: A read that misses the buffer issues exactly one internal transfer with `ia_we`=0, `ia_be`=all ones and `ia_line`=addr[15:3]. It then pulses `rdy` with halfword addr[2:0] of the returned line, where halfword k occupies bits 16k+15:16k.
- R3: A read to the line currently held as read data returns its halfword with `rdy` one cycle after `sel`, with no internal transfer.
- R4: A write to the line being gathered, or any write while no write data is pending, is acknowledged one cycle after `sel` with no internal transfer.
- R5: A write to a different line than the one holding pending writes first commits that line: `ia_we`=1, `ia_line`=the buffered line, and `ia_be` bits 2k and 2k+1 set exactly for the written halfwords k. Unwritten halfwords in memory stay unchanged.
- R6: When `hold_req` drops while writes are pending, the line is committed before `hold_ack` falls.
- R7: Any read while writes are pending commits them first and then refetches, so the read returns the merged data.
- R8: With `cache_mode`=1 and `hit`=1 for `lk_line`, the transfer (read or commit) goes to the cache port only.
- R9: With `cache_mode`=1 and `hit`=0, the transfer goes to the memory port only, and the cache port sees no fill and no write.
- R10: With `cache_mode`=0, every transfer goes to the memory port regardless of `hit`.
- R11: Dropping hold invalidates buffered read data, so the first read after a new grant refetches.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| hold_req | input | 1 | Master requests the bus |
| hold_ack | output | 1 | Bus granted to master |
| sel | input | 1 | One-cycle access strobe |
| wr | input | 1 | 1 = write, 0 = read |
| addr | input | 16 | Halfword address; [15:3] line, [2:0] halfword |
| wdata | input | 16 | Write halfword |
| rdata | output | 16 | Read halfword, valid with rdy |
| rdy | output | 1 | One-cycle end-of-access pulse |
| cache_mode | input | 1 | Enables hit/miss routing |
| lk_line | output | 13 | Line being looked up for a hit |
| hit | input | 1 | Cache hit for lk_line |
| ia_we | output | 1 | Internal transfer is a write |
| ia_line | output | 13 | Internal line address |
| ia_be | output | 16 | Internal byte enables |
| ia_wdata | output | 128 | Internal write line |
| mem_req | output | 1 | Memory port request, held until ack |
| mem_ack | input | 1 | Memory port completion |
| mem_rdata | input | 128 | Memory port read line |
| cache_req | output | 1 | Cache port request, held until ack |
| cache_ack | input | 1 | Cache port completion |
| cache_rdata | input | 128 | Cache port read line |

## Verification
A buffer hit puts `rdy` high one cycle after the `sel` strobe. The bench therefore samples at the falling edge that follows, and checks that the latency is exactly one cycle with no internal transfer counted. Misses, commits and refetches each pass through a lookup cycle, a request cycle and the responder's delay. For these the bench waits for the `rdy` pulse or the falling `hold_ack`, then compares the read value, the number of memory and cache handshakes, and the contents of its own memory and cache models. Grant is checked one cycle after `hold_req`. Ignored strobes are checked over a window of several cycles.

// File: rtl/lb_pkg.sv
package lb_pkg;
  typedef enum logic [1:0] {ST_OFF, ST_HELD, ST_LOOK, ST_WAIT} lb_state_t;
  typedef enum logic [1:0] {BM_NONE, BM_READ, BM_WRITE} lb_mode_t;
  typedef enum logic [1:0] {PD_READ, PD_WRITE, PD_REL} lb_pend_t;
  typedef enum logic {JB_FLUSH, JB_FETCH} lb_job_t;
endpackage

// File: rtl/lb_line_buf.sv
module lb_line_buf #(
  parameter int HW = 16,
  parameter int NHW = 8,
  localparam int IW = HW * NHW,
  localparam int IDXW = $clog2(NHW)
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            clr,
  input  logic            ld,
  input  logic [IW-1:0]   ld_data,
  input  logic            wr_en,
  input  logic [IDXW-1:0] wr_idx,
  input  logic [HW-1:0]   wr_data,
  output logic [IW-1:0]   data,
  output logic [NHW-1:0]  mask
);
  logic [HW-1:0] hw_q [NHW];

  for (genvar k = 0; k < NHW; k++) begin : g_hw
    always_ff @(posedge clk) begin
      if (ld) hw_q[k] <= ld_data[k*HW +: HW];
      else if (wr_en && wr_idx == IDXW'(k)) hw_q[k] <= wr_data;
    end
    assign data[k*HW +: HW] = hw_q[k];
  end

  always_ff @(posedge clk) begin
    if (rst) mask <= '0;
    else begin
      if (clr) mask <= '0;
      if (wr_en) mask[wr_idx] <= 1'b1;
    end
  end

  // R4
  gather_mark_chk: assert property (@(posedge clk) disable iff (rst)
    wr_en |=> mask[$past(wr_idx)]);
endmodule

// File: rtl/lb_router.sv
module lb_router #(
  parameter int IW = 128,
  parameter int LW = 13,
  localparam int BEW = IW / 8
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           issue,
  input  logic           iss_we,
  input  logic [LW-1:0]  iss_line,
  input  logic [BEW-1:0] iss_be,
  input  logic [IW-1:0]  iss_wdata,
  input  logic           cache_mode,
  input  logic           hit,
  output logic           ia_we,
  output logic [LW-1:0]  ia_line,
  output logic [BEW-1:0] ia_be,
  output logic [IW-1:0]  ia_wdata,
  output logic           mem_req,
  input  logic           mem_ack,
  input  logic [IW-1:0]  mem_rdata,
  output logic           cache_req,
  input  logic           cache_ack,
  input  logic [IW-1:0]  cache_rdata,
  output logic           done,
  output logic [IW-1:0]  rd_line
);
  logic to_cache;
  logic go_cache;

  assign go_cache = cache_mode && hit;
  assign done = (mem_req && mem_ack) || (cache_req && cache_ack);
  assign rd_line = to_cache ? cache_rdata : mem_rdata;

  always_ff @(posedge clk) begin
    if (rst) begin
      mem_req <= 1'b0;
      cache_req <= 1'b0;
      to_cache <= 1'b0;
      ia_we <= 1'b0;
      ia_line <= '0;
      ia_be <= '0;
      ia_wdata <= '0;
    end else if (issue) begin
      to_cache <= go_cache;
      cache_req <= go_cache;
      mem_req <= !go_cache;
      ia_we <= iss_we;
      ia_line <= iss_line;
      ia_be <= iss_be;
      ia_wdata <= iss_wdata;
    end else if (done) begin
      mem_req <= 1'b0;
      cache_req <= 1'b0;
    end
  end

  // R8
  route_cache_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(cache_req) |-> $past(cache_mode && hit));
  // R9 R10
  route_mem_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(mem_req) |-> $past(!(cache_mode && hit)));
  // R2
  mem_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (mem_req && !mem_ack) |=> mem_req);
  // R8
  cache_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (cache_req && !cache_ack) |=> cache_req);
endmodule

// File: rtl/lb_ctrl.sv
module lb_ctrl
  import lb_pkg::*;
#(
  parameter int AW = 16,
  parameter int HW = 16,
  parameter int NHW = 8,
  localparam int IW = HW * NHW,
  localparam int IDXW = $clog2(NHW),
  localparam int LW = AW - IDXW,
  localparam int BEW = IW / 8
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            hold_req,
  output logic            hold_ack,
  input  logic            sel,
  input  logic            wr,
  input  logic [AW-1:0]   addr,
  input  logic [HW-1:0]   wdata,
  output logic [HW-1:0]   rdata,
  output logic            rdy,
  output logic [LW-1:0]   lk_line,
  input  logic [IW-1:0]   buf_data,
  input  logic [NHW-1:0]  buf_mask,
  output logic            buf_clr,
  output logic            buf_ld,
  output logic            buf_wr,
  output logic [IDXW-1:0] buf_idx,
  output logic [HW-1:0]   buf_wdata,
  output logic            issue,
  output logic            iss_we,
  output logic [BEW-1:0]  iss_be,
  input  logic            done,
  input  logic [IW-1:0]   rd_line
);
  lb_state_t st;
  lb_mode_t  mode;
  lb_pend_t  pend;
  lb_job_t   job;
  logic [LW-1:0]   buf_line, pend_line, a_line;
  logic [IDXW-1:0] pend_idx, a_idx;
  logic [HW-1:0]   pend_wdata;
  logic            take, write_ok, rd_hit, flush_done, fetch_done;

  assign a_line = addr[AW-1:IDXW];
  assign a_idx = addr[IDXW-1:0];
  assign take = (st == ST_HELD) && hold_req && sel;
  assign write_ok = (mode != BM_WRITE) || (a_line == buf_line);
  assign rd_hit = (mode == BM_READ) && (a_line == buf_line);
  assign flush_done = (st == ST_WAIT) && done && (job == JB_FLUSH);
  assign fetch_done = (st == ST_WAIT) && done && (job == JB_FETCH);
  assign issue = (st == ST_LOOK);
  assign iss_we = (job == JB_FLUSH);

  always_comb begin
    for (int k = 0; k < NHW; k++)
      iss_be[2*k +: 2] = iss_we ? {2{buf_mask[k]}} : 2'b11;
  end

  always_comb begin
    buf_clr = 1'b0;
    buf_ld = 1'b0;
    buf_wr = 1'b0;
    buf_idx = a_idx;
    buf_wdata = wdata;
    if (take && wr && write_ok) begin
      buf_wr = 1'b1;
      buf_clr = (mode != BM_WRITE);
    end else if (flush_done) begin
      buf_clr = 1'b1;
      if (pend == PD_WRITE) begin
        buf_wr = 1'b1;
        buf_idx = pend_idx;
        buf_wdata = pend_wdata;
      end
    end else if (fetch_done) begin
      buf_ld = 1'b1;
      buf_clr = 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st <= ST_OFF;
      mode <= BM_NONE;
      pend <= PD_READ;
      job <= JB_FETCH;
      buf_line <= '0;
      pend_line <= '0;
      pend_idx <= '0;
      pend_wdata <= '0;
      lk_line <= '0;
      hold_ack <= 1'b0;
      rdy <= 1'b0;
      rdata <= '0;
    end else begin
      rdy <= 1'b0;
      case (st)
        ST_OFF: begin
          if (hold_req) begin
            hold_ack <= 1'b1;
            st <= ST_HELD;
          end
        end
        ST_HELD: begin
          if (!hold_req) begin
            if (mode == BM_WRITE) begin
              job <= JB_FLUSH;
              lk_line <= buf_line;
              pend <= PD_REL;
              st <= ST_LOOK;
            end else begin
              mode <= BM_NONE;
              hold_ack <= 1'b0;
              st <= ST_OFF;
            end
          end else if (sel) begin
            pend_line <= a_line;
            pend_idx <= a_idx;
            pend_wdata <= wdata;
            if (wr) begin
              if (write_ok) begin
                mode <= BM_WRITE;
                buf_line <= a_line;
                rdy <= 1'b1;
              end else begin
                job <= JB_FLUSH;
                lk_line <= buf_line;
                pend <= PD_WRITE;
                st <= ST_LOOK;
              end
            end else if (rd_hit) begin
              rdata <= buf_data[a_idx*HW +: HW];
              rdy <= 1'b1;
            end else if (mode == BM_WRITE) begin
              job <= JB_FLUSH;
              lk_line <= buf_line;
              pend <= PD_READ;
              st <= ST_LOOK;
            end else begin
              job <= JB_FETCH;
              lk_line <= a_line;
              pend <= PD_READ;
              st <= ST_LOOK;
            end
          end
        end
        ST_LOOK: st <= ST_WAIT;
        ST_WAIT: begin
          if (done) begin
            if (job == JB_FLUSH) begin
              mode <= BM_NONE;
              case (pend)
                PD_REL: begin
                  hold_ack <= 1'b0;
                  st <= ST_OFF;
                end
                PD_READ: begin
                  job <= JB_FETCH;
                  lk_line <= pend_line;
                  st <= ST_LOOK;
                end
                default: begin
                  mode <= BM_WRITE;
                  buf_line <= pend_line;
                  rdy <= 1'b1;
                  st <= ST_HELD;
                end
              endcase
            end else begin
              mode <= BM_READ;
              buf_line <= pend_line;
              rdata <= rd_line[pend_idx*HW +: HW];
              rdy <= 1'b1;
              st <= ST_HELD;
            end
          end
        end
        default: st <= ST_OFF;
      endcase
    end
  end

  // R1
  grant_req_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(hold_ack) |-> $past(hold_req));
  // R1
  rdy_granted_chk: assert property (@(posedge clk) disable iff (rst)
    rdy |-> hold_ack);
  // R6
  release_flushed_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(hold_ack) |-> (buf_mask == '0));
endmodule

// File: rtl/xm_line_bridge.sv
module xm_line_bridge #(
  parameter int AW = 16,
  parameter int HW = 16,
  parameter int NHW = 8,
  localparam int IW = HW * NHW,
  localparam int IDXW = $clog2(NHW),
  localparam int LW = AW - IDXW,
  localparam int BEW = IW / 8
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           hold_req,
  output logic           hold_ack,
  input  logic           sel,
  input  logic           wr,
  input  logic [AW-1:0]  addr,
  input  logic [HW-1:0]  wdata,
  output logic [HW-1:0]  rdata,
  output logic           rdy,
  input  logic           cache_mode,
  output logic [LW-1:0]  lk_line,
  input  logic           hit,
  output logic           ia_we,
  output logic [LW-1:0]  ia_line,
  output logic [BEW-1:0] ia_be,
  output logic [IW-1:0]  ia_wdata,
  output logic           mem_req,
  input  logic           mem_ack,
  input  logic [IW-1:0]  mem_rdata,
  output logic           cache_req,
  input  logic           cache_ack,
  input  logic [IW-1:0]  cache_rdata
);
  logic [IW-1:0]   buf_data, rd_line;
  logic [NHW-1:0]  buf_mask;
  logic            buf_clr, buf_ld, buf_wr, issue, iss_we, done;
  logic [IDXW-1:0] buf_idx;
  logic [HW-1:0]   buf_wdata;
  logic [BEW-1:0]  iss_be;

  lb_ctrl #(.AW(AW), .HW(HW), .NHW(NHW)) u_ctrl (
    .clk(clk), .rst(rst), .hold_req(hold_req), .hold_ack(hold_ack),
    .sel(sel), .wr(wr), .addr(addr), .wdata(wdata), .rdata(rdata), .rdy(rdy),
    .lk_line(lk_line), .buf_data(buf_data), .buf_mask(buf_mask),
    .buf_clr(buf_clr), .buf_ld(buf_ld), .buf_wr(buf_wr), .buf_idx(buf_idx),
    .buf_wdata(buf_wdata), .issue(issue), .iss_we(iss_we), .iss_be(iss_be),
    .done(done), .rd_line(rd_line)
  );

  lb_line_buf #(.HW(HW), .NHW(NHW)) u_buf (
    .clk(clk), .rst(rst), .clr(buf_clr), .ld(buf_ld), .ld_data(rd_line),
    .wr_en(buf_wr), .wr_idx(buf_idx), .wr_data(buf_wdata),
    .data(buf_data), .mask(buf_mask)
  );

  lb_router #(.IW(IW), .LW(LW)) u_route (
    .clk(clk), .rst(rst), .issue(issue), .iss_we(iss_we), .iss_line(lk_line),
    .iss_be(iss_be), .iss_wdata(buf_data), .cache_mode(cache_mode), .hit(hit),
    .ia_we(ia_we), .ia_line(ia_line), .ia_be(ia_be), .ia_wdata(ia_wdata),
    .mem_req(mem_req), .mem_ack(mem_ack), .mem_rdata(mem_rdata),
    .cache_req(cache_req), .cache_ack(cache_ack), .cache_rdata(cache_rdata),
    .done(done), .rd_line(rd_line)
  );
endmodule

// File: tb/test_xm_line_bridge.sv
module test_xm_line_bridge;
  logic clk = 0, rst = 1;
  logic hold_req = 0, sel = 0, wr = 0, cache_mode = 0;
  logic [15:0] addr = 0, wdata = 0;
  logic hold_ack, rdy, ia_we, mem_req, cache_req, hit;
  logic [15:0] rdata, ia_be;
  logic [12:0] lk_line, ia_line, hit_line = 13'h1fff;
  logic [127:0] ia_wdata, mem_rdata = 0, cache_rdata = 0;
  logic mem_ack = 0, cache_ack = 0;
  logic [127:0] mem_m [16];
  logic [127:0] cache_m [16];
  int md = 0, cd = 0, n_mem = 0, n_cache = 0, errors = 0, checks = 0;
  logic [15:0] last_be;
  logic [12:0] last_line;
  logic last_we;

  always #10 clk = ~clk;
  assign hit = (lk_line == hit_line);

  xm_line_bridge i_xm_line_bridge (
    .clk(clk), .rst(rst), .hold_req(hold_req), .hold_ack(hold_ack),
    .sel(sel), .wr(wr), .addr(addr), .wdata(wdata), .rdata(rdata), .rdy(rdy),
    .cache_mode(cache_mode), .lk_line(lk_line), .hit(hit),
    .ia_we(ia_we), .ia_line(ia_line), .ia_be(ia_be), .ia_wdata(ia_wdata),
    .mem_req(mem_req), .mem_ack(mem_ack), .mem_rdata(mem_rdata),
    .cache_req(cache_req), .cache_ack(cache_ack), .cache_rdata(cache_rdata)
  );

  initial begin
    for (int l = 0; l < 16; l++)
      for (int w = 0; w < 8; w++) begin
        mem_m[l][16*w +: 16] = {4'hA, 4'(l), 4'h0, 1'b0, 3'(w)};
        cache_m[l][16*w +: 16] = {4'hC, 4'(l), 4'h0, 1'b0, 3'(w)};
      end
  end

  always @(posedge clk) begin
    if (mem_req && mem_ack) begin
      n_mem <= n_mem + 1;
      last_be <= ia_be; last_line <= ia_line; last_we <= ia_we;
    end
    if (cache_req && cache_ack) begin
      n_cache <= n_cache + 1;
      last_be <= ia_be; last_line <= ia_line; last_we <= ia_we;
    end
    if (mem_req && !mem_ack) begin
      if (md == 1) begin
        mem_ack <= 1; md <= 0;
        mem_rdata <= mem_m[ia_line[3:0]];
        if (ia_we)
          for (int b = 0; b < 16; b++)
            if (ia_be[b]) mem_m[ia_line[3:0]][8*b +: 8] <= ia_wdata[8*b +: 8];
      end else md <= md + 1;
    end else mem_ack <= 0;
    if (cache_req && !cache_ack) begin
      if (cd == 1) begin
        cache_ack <= 1; cd <= 0;
        cache_rdata <= cache_m[ia_line[3:0]];
        if (ia_we)
          for (int b = 0; b < 16; b++)
            if (ia_be[b]) cache_m[ia_line[3:0]][8*b +: 8] <= ia_wdata[8*b +: 8];
      end else cd <= cd + 1;
    end else cache_ack <= 0;
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic access(input logic w, input logic [15:0] a, input logic [15:0] d,
                        output logic [15:0] got, output int lat);
    @(negedge clk);
    sel = 1; wr = w; addr = a; wdata = d;
    lat = 99;
    for (int i = 1; i < 60; i++) begin
      @(negedge clk);
      sel = 0;
      if (rdy) begin lat = i; break; end
    end
    got = rdata;
  endtask

  task automatic release_hold(output int cyc);
    @(negedge clk);
    hold_req = 0;
    cyc = 99;
    for (int i = 1; i < 60; i++) begin
      @(negedge clk);
      if (!hold_ack) begin cyc = i; break; end
    end
  endtask

  task automatic grant;
    @(negedge clk);
    hold_req = 1;
    @(negedge clk);
    check("R1 grant", 32'(hold_ack), 32'd1);
  endtask

  // {wr, addr, wdata, expected rdata, internal transfers}
  localparam logic [52:0] VEC [14] = '{
    {1'b0, 16'h0010, 16'h0000, 16'hA200, 4'd1},
    {1'b0, 16'h0013, 16'h0000, 16'hA203, 4'd0},
    {1'b0, 16'h0017, 16'h0000, 16'hA207, 4'd0},
    {1'b0, 16'h0018, 16'h0000, 16'hA300, 4'd1},
    {1'b1, 16'h0021, 16'h1111, 16'h0000, 4'd0},
    {1'b1, 16'h0025, 16'h5555, 16'h0000, 4'd0},
    {1'b0, 16'h0024, 16'h0000, 16'hA404, 4'd2},
    {1'b0, 16'h0021, 16'h0000, 16'h1111, 4'd0},
    {1'b0, 16'h0025, 16'h0000, 16'h5555, 4'd0},
    {1'b1, 16'h0030, 16'h6060, 16'h0000, 4'd0},
    {1'b1, 16'h0038, 16'h7070, 16'h0000, 4'd1},
    {1'b0, 16'h0031, 16'h0000, 16'hA601, 4'd2},
    {1'b0, 16'h0030, 16'h0000, 16'h6060, 4'd0},
    {1'b0, 16'h0038, 16'h0000, 16'h7070, 4'd1}
  };

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks + 1);
    $finish;
  end

  initial begin
    logic [15:0] got;
    int lat, m0, c0, cyc;
    bit seen;
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    check("R1 reset hold_ack", 32'(hold_ack), 0);
    check("R1 reset rdy", 32'(rdy), 0);
    check("R2 reset reqs", {30'd0, mem_req, cache_req}, 0);
    grant();

    foreach (VEC[i]) begin
      m0 = n_mem;
      access(VEC[i][52], VEC[i][51:36], VEC[i][35:20], got, lat);
      if (!VEC[i][52]) check(VEC[i][3:0] == 0 ? "R3 read value" : "R2/R7 read value",
                             32'(got), 32'(VEC[i][19:4]));
      check(VEC[i][52] ? "R4 R5 transfers" : "R3 R7 transfers", n_mem - m0, 32'(VEC[i][3:0]));
      if (VEC[i][3:0] == 0) check(VEC[i][52] ? "R4 latency" : "R3 latency", lat, 1);
    end
    check("R2 fetch we", 32'(last_we), 0);
    check("R2 fetch be", 32'(last_be), 32'hFFFF);
    check("R2 fetch line", 32'(last_line), 7);

    access(1, 16'h0041, 16'hAAAA, got, lat);
    access(1, 16'h0046, 16'hBBBB, got, lat);
    access(1, 16'h0048, 16'hCCCC, got, lat);
    check("R5 commit be", 32'(last_be), 32'h300C);
    check("R5 commit we", 32'(last_we), 1);
    check("R5 commit line", 32'(last_line), 8);
    check("R5 merged data", {mem_m[8][111:96], mem_m[8][31:16]}, 32'hBBBBAAAA);
    check("R5 untouched halfword", 32'(mem_m[8][15:0]), 32'hA800);

    m0 = n_mem;
    release_hold(cyc);
    check("R6 release commit", n_mem - m0, 1);
    check("R6 released data", 32'(mem_m[9][15:0]), 32'hCCCC);
    check("R6 hold_ack low", 32'(hold_ack), 0);

    m0 = n_mem; seen = 0;
    @(negedge clk); sel = 1; wr = 0; addr = 16'h0010;
    @(negedge clk); sel = 0;
    for (int i = 0; i < 6; i++) begin
      if (rdy || mem_req || cache_req) seen = 1;
      @(negedge clk);
    end
    check("R1 sel ignored", {31'd0, seen}, 0);
    check("R1 no transfer", n_mem - m0, 0);
    grant();

    m0 = n_mem;
    access(0, 16'h0050, 0, got, lat);
    check("R11 first read", 32'(got), 32'hAA00);
    release_hold(cyc);
    check("R11 clean release", n_mem - m0, 1);
    grant();
    m0 = n_mem;
    access(0, 16'h0050, 0, got, lat);
    check("R11 refetch", n_mem - m0, 1);

    cache_mode = 1; hit_line = 13'd12;
    m0 = n_mem; c0 = n_cache;
    access(0, 16'h0060, 0, got, lat);
    check("R8 read hit value", 32'(got), 32'hCC00);
    check("R8 read hit ports", {n_cache - c0, n_mem - m0}, {32'd1, 32'd0});
    m0 = n_mem; c0 = n_cache;
    access(0, 16'h0068, 0, got, lat);
    check("R9 read miss value", 32'(got), 32'hAD00);
    check("R9 read miss ports", {n_cache - c0, n_mem - m0}, {32'd0, 32'd1});
    access(1, 16'h0061, 16'h1234, got, lat);
    m0 = n_mem; c0 = n_cache;
    access(1, 16'h0069, 16'h4321, got, lat);
    check("R8 write hit ports", {n_cache - c0, n_mem - m0}, {32'd1, 32'd0});
    check("R8 cache written", 32'(cache_m[12][31:16]), 32'h1234);
    check("R8 memory untouched", 32'(mem_m[12][31:16]), 32'hAC01);
    m0 = n_mem; c0 = n_cache;
    release_hold(cyc);
    check("R9 write miss ports", {n_cache - c0, n_mem - m0}, {32'd0, 32'd1});
    check("R9 memory written", 32'(mem_m[13][31:16]), 32'h4321);
    check("R9 cache untouched", 32'(cache_m[13][31:16]), 32'hCD01);

    grant();
    cache_mode = 0; hit_line = 13'd14;
    m0 = n_mem; c0 = n_cache;
    access(0, 16'h0070, 0, got, lat);
    check("R10 value", 32'(got), 32'hAE00);
    check("R10 ports", {n_cache - c0, n_mem - m0}, {32'd0, 32'd1});

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule